// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a set of maskable interrupt request lines and hands the most urgent one to a processor core. Each channel carries a 4-bit priority (a lower value is more urgent), an enable bit and a pending bit. The controller picks a winner, holds it through a fixed entry phase, and then marks the handler as running. While that handler runs, the controller watches for requests urgent enough to preempt it. It keeps a stack of suspended handlers so that each exit resumes the handler below.

Two features keep latency low. During the entry phase a request that arrives late, but is strictly more urgent, takes over the slot that is being entered, and the window does not restart. When a handler exits and a pending request is urgent enough to run, the controller goes straight into that request's entry phase and never passes through the idle state. Software sets priorities and enables through a small valid/ready register port. The vector number is handed to the core directly on dedicated outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, entry_o, active_o, start_o and reg_ready_o are 0, and every channel reads back as 0.
- R2: A register access holds reg_valid_i. reg_ready_o rises one cycle later for exactly one cycle, and the access completes at that edge. The address is the channel number. Write data bits [3:0] are the priority and bit 8 is the enable. A read returns priority in [3:0], enable in bit 8 and pending in bit 16. Addresses at or above the channel count read as 0, and writes to them are dropped.
- R3: A request line that is high at a clock edge sets that channel's pending bit, even if the channel is disabled. A disabled channel is never entered. Once it is enabled, it is entered while still pending.
- R4: Among the channels that are pending and enabled, the lowest priority value wins. On a tie, the lower channel number wins. The vector number is the channel number plus VEC_BASE.
- R5: From idle, entry_o goes high on the cycle after a pending bit is set and stays high for ENTRY_CYCLES cycles, with entry_vec_o showing the winner. After that, active_o goes high, start_o pulses for one cycle, and the winner's pending bit is cleared.
- R6: During the entry phase, a pending request with a strictly lower priority value replaces the candidate one cycle after its pending bit is set, and the window length stays the same. A request of equal priority does not replace the candidate.
- R7: A running handler is preempted only by a request whose priority value is strictly lower than its own. In that case a new entry phase starts, and the suspended handler is stacked.
- R8: On exit, if no pending request is more urgent than the next stacked handler, that handler resumes in the next cycle. If the stack is empty, the controller returns to idle.
- R9: On exit, if a pending request is more urgent than the next stacked handler (or the stack is empty), its entry phase starts in the next cycle without an idle cycle (tail-chaining).
- R10: exit_i has no effect unless a handler is active: it is ignored in idle and during an entry phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NUM_IRQ | Interrupt request lines, one per channel |
| reg_valid_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Channel number addressed |
| reg_wdata_i | input | DATA_W | Write data |
| reg_ready_o | output | 1 | Access completes this cycle |
| reg_rdata_o | output | DATA_W | Read data, valid while reg_ready_o is high |
| entry_o | output | 1 | Entry phase in progress |
| entry_vec_o | output | VEC_W | Vector number being entered |
| start_o | output | 1 | One-cycle pulse: handler has begun |
| active_o | output | 1 | A handler is running |
| active_vec_o | output | VEC_W | Vector number of the running handler |
| active_prio_o | output | 4 | Priority of the running handler |
| exit_i | input | 1 | Core reports that the running handler has finished |

## Verification
A request pulse seen at edge e0 sets pending at that edge, raises entry_o after e0+1 and raises active_o and start_o after e0+1+ENTRY_CYCLES. An exit strobed at edge x shows its result (tail-chain entry, resume or idle) right after x. A late arrival seen at edge k replaces the candidate after k+1. Register read data and ready are due one cycle after valid, and writes take effect at the second edge. The bench drives inputs on the falling edge and counts rising edges exactly to those points before sampling. Its expected winners come from a priority model that is fed only by the writes and pulses the bench itself issued.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned PRIO_W       = 4;
    localparam int unsigned IDX_W        = 8;
    localparam int unsigned LEVELS       = 1 << PRIO_W;
    localparam int unsigned CFG_EN_BIT   = 8;
    localparam int unsigned CFG_PEND_BIT = 16;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // A competitor: valid flag, channel index, priority value
    typedef struct packed {
        logic  valid;
        idx_t  idx;
        prio_t prio;
    } cand_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_ACTIVE = 2'd2
    } seq_state_e;

    // a beats b when a exists and b is absent or strictly less urgent
    function automatic logic more_urgent(input cand_t a, input cand_t b);
        return a.valid && (!b.valid || (a.prio < b.prio));
    endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 41,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_IRQ-1:0]    irq_i,
    input  logic                  reg_valid_i,
    input  logic                  reg_we_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic                  reg_ready_o,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  clr_vld_i,
    input  idx_t                  clr_idx_i,
    output prio_t [NUM_IRQ-1:0]   prio_o,
    output logic  [NUM_IRQ-1:0]   en_o,
    output logic  [NUM_IRQ-1:0]   pend_o
);
    localparam logic [ADDR_W:0] ADDR_LIMIT = (ADDR_W+1)'(NUM_IRQ);

    prio_t [NUM_IRQ-1:0] prio_q;
    logic  [NUM_IRQ-1:0] en_q;
    logic  [NUM_IRQ-1:0] pend_q;
    logic                ready_q;
    logic                in_range;
    logic                accept;
    logic                unused_wdata;

    assign in_range     = {1'b0, reg_addr_i} < ADDR_LIMIT;
    assign accept       = reg_valid_i && ready_q;
    assign unused_wdata = ^reg_wdata_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            prio_q  <= '0;
            en_q    <= '0;
            pend_q  <= '0;
        end else begin
            ready_q <= reg_valid_i && !ready_q;
            if (accept && reg_we_i && in_range) begin
                prio_q[reg_addr_i] <= reg_wdata_i[PRIO_W-1:0];
                en_q[reg_addr_i]   <= reg_wdata_i[CFG_EN_BIT];
            end
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (irq_i[i]) begin
                    pend_q[i] <= 1'b1;
                end else if (clr_vld_i && (clr_idx_i == IDX_W'(i))) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (ready_q && in_range) begin
            reg_rdata_o[PRIO_W-1:0]   = prio_q[reg_addr_i];
            reg_rdata_o[CFG_EN_BIT]   = en_q[reg_addr_i];
            reg_rdata_o[CFG_PEND_BIT] = pend_q[reg_addr_i];
        end
    end

    assign reg_ready_o = ready_q;
    assign prio_o      = prio_q;
    assign en_o        = en_q;
    assign pend_o      = pend_q;

    // R2
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready_q |=> !ready_q);

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_i != '0) |=> ((pend_q & $past(irq_i)) == $past(irq_i)));
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 41
) (
    input  prio_t [NUM_IRQ-1:0] prio_i,
    input  logic  [NUM_IRQ-1:0] en_i,
    input  logic  [NUM_IRQ-1:0] pend_i,
    output cand_t               best_o
);
    // Ascending scan with strict compare: lower index keeps ties
    always_comb begin
        best_o = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (en_i[i] && pend_i[i] && (!best_o.valid || (prio_i[i] < best_o.prio))) begin
                best_o.valid = 1'b1;
                best_o.idx   = IDX_W'(i);
                best_o.prio  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/pic_sequencer.sv
module pic_sequencer
    import pic_pkg::*;
#(
    parameter int unsigned ENTRY_CYCLES = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  cand_t best_i,
    input  logic  exit_i,
    output logic  entry_o,
    output cand_t ent_cand_o,
    output logic  active_o,
    output cand_t act_cand_o,
    output logic  start_o,
    output logic  clr_vld_o,
    output idx_t  clr_idx_o
);
    localparam int unsigned DEPTH = LEVELS;
    localparam int unsigned IW    = $clog2(DEPTH);
    localparam int unsigned SP_W  = IW + 1;
    localparam int unsigned CNT_W = (ENTRY_CYCLES > 1) ? $clog2(ENTRY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    cand_t             cand_q;
    cand_t             stk_q [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic              start_q;

    cand_t top_c;
    cand_t below_c;
    cand_t chosen_c;
    logic  last_c;

    always_comb begin
        top_c   = '0;
        below_c = '0;
        if (sp_q != '0)          top_c   = stk_q[IW'(sp_q - SP_W'(1))];
        if (sp_q > SP_W'(1))     below_c = stk_q[IW'(sp_q - SP_W'(2))];
        chosen_c = more_urgent(best_i, cand_q) ? best_i : cand_q;
        last_c   = (cnt_q == CNT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cand_q  <= '0;
            sp_q    <= '0;
            start_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (best_i.valid) begin
                        state_q <= ST_ENTRY;
                        cand_q  <= best_i;
                        cnt_q   <= '0;
                    end
                end
                ST_ENTRY: begin
                    if (last_c) begin
                        stk_q[IW'(sp_q)] <= chosen_c;
                        sp_q    <= sp_q + SP_W'(1);
                        state_q <= ST_ACTIVE;
                        start_q <= 1'b1;
                    end else begin
                        cand_q <= chosen_c;
                        cnt_q  <= cnt_q + CNT_W'(1);
                    end
                end
                ST_ACTIVE: begin
                    if (exit_i) begin
                        sp_q <= sp_q - SP_W'(1);
                        if (more_urgent(best_i, below_c)) begin
                            state_q <= ST_ENTRY;
                            cand_q  <= best_i;
                            cnt_q   <= '0;
                        end else if (sp_q == SP_W'(1)) begin
                            state_q <= ST_IDLE;
                        end
                    end else if (more_urgent(best_i, top_c)) begin
                        state_q <= ST_ENTRY;
                        cand_q  <= best_i;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign entry_o    = (state_q == ST_ENTRY);
    assign active_o   = (state_q == ST_ACTIVE);
    assign ent_cand_o = cand_q;
    assign act_cand_o = top_c;
    assign start_o    = start_q;
    assign clr_vld_o  = (state_q == ST_ENTRY) && last_c;
    assign clr_idx_o  = chosen_c.idx;

    // R5
    start_after_entry_chk: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (state_q == ST_ACTIVE) && $past(state_q == ST_ENTRY));

    // R6
    late_mono_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ENTRY) && $past(state_q == ST_ENTRY) |-> (cand_q.prio <= $past(cand_q.prio)));

    // R7
    nest_order_chk: assert property (@(posedge clk) disable iff (rst)
        (sp_q >= SP_W'(2)) |-> (top_c.prio < below_c.prio));

    // R8
    idle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> (sp_q == '0));

    // R9
    tail_chain_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE) && exit_i && best_i.valid && (sp_q == SP_W'(1)) |=> (state_q == ST_ENTRY));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ      = 41,
    parameter int unsigned ENTRY_CYCLES = 4,
    parameter int unsigned VEC_BASE     = 16,
    parameter int unsigned VEC_W        = 8,
    parameter int unsigned DATA_W       = 32,
    localparam int unsigned ADDR_W      = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IRQ-1:0]  irq_i,
    input  logic                reg_valid_i,
    input  logic                reg_we_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [DATA_W-1:0]   reg_wdata_i,
    output logic                reg_ready_o,
    output logic [DATA_W-1:0]   reg_rdata_o,
    output logic                entry_o,
    output logic [VEC_W-1:0]    entry_vec_o,
    output logic                start_o,
    output logic                active_o,
    output logic [VEC_W-1:0]    active_vec_o,
    output logic [PRIO_W-1:0]   active_prio_o,
    input  logic                exit_i
);
    prio_t [NUM_IRQ-1:0] prio_w;
    logic  [NUM_IRQ-1:0] en_w;
    logic  [NUM_IRQ-1:0] pend_w;
    cand_t               best_w;
    cand_t               ent_w;
    cand_t               act_w;
    logic                clr_vld_w;
    idx_t                clr_idx_w;
    logic                unused_flags;

    pic_regs #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .irq_i       (irq_i),
        .reg_valid_i (reg_valid_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_ready_o (reg_ready_o),
        .reg_rdata_o (reg_rdata_o),
        .clr_vld_i   (clr_vld_w),
        .clr_idx_i   (clr_idx_w),
        .prio_o      (prio_w),
        .en_o        (en_w),
        .pend_o      (pend_w)
    );

    pic_arbiter #(
        .NUM_IRQ (NUM_IRQ)
    ) u_arb (
        .prio_i (prio_w),
        .en_i   (en_w),
        .pend_i (pend_w),
        .best_o (best_w)
    );

    pic_sequencer #(
        .ENTRY_CYCLES (ENTRY_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .best_i     (best_w),
        .exit_i     (exit_i),
        .entry_o    (entry_o),
        .ent_cand_o (ent_w),
        .active_o   (active_o),
        .act_cand_o (act_w),
        .start_o    (start_o),
        .clr_vld_o  (clr_vld_w),
        .clr_idx_o  (clr_idx_w)
    );

    assign unused_flags  = ent_w.valid ^ act_w.valid;
    assign entry_vec_o   = entry_o  ? (VEC_W'(ent_w.idx) + VEC_W'(VEC_BASE)) : '0;
    assign active_vec_o  = active_o ? (VEC_W'(act_w.idx) + VEC_W'(VEC_BASE)) : '0;
    assign active_prio_o = active_o ? act_w.prio : '0;
endmodule

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 41;
    localparam int E  = 4;
    localparam int VB = 16;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq = '0;
    logic          reg_valid = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_ready;
    logic [31:0]   reg_rdata;
    logic          entry_o, start_o, active_o, exit_i;
    logic [7:0]    entry_vec_o, active_vec_o;
    logic [3:0]    active_prio_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [3:0] m_prio [N];
    bit         m_en   [N];
    bit         m_pend [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl #(.NUM_IRQ(N), .ENTRY_CYCLES(E), .VEC_BASE(VB)) uut (
        .clk(clk), .rst(rst), .irq_i(irq),
        .reg_valid_i(reg_valid), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_ready_o(reg_ready), .reg_rdata_o(reg_rdata),
        .entry_o(entry_o), .entry_vec_o(entry_vec_o), .start_o(start_o),
        .active_o(active_o), .active_vec_o(active_vec_o), .active_prio_o(active_prio_o),
        .exit_i(exit_i)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model_best();
        int b = -1;
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pend[i] && (b < 0 || m_prio[i] < m_prio[b])) b = i;
        return b;
    endfunction

    task automatic reg_access(input bit we, input int addr, input int wdata, output int rdata);
        reg_valid = 1'b1; reg_we = we; reg_addr = AW'(addr); reg_wdata = 32'(wdata);
        tick(1);
        chk(reg_ready == 1'b1, "R2", "ready one cycle after valid", reg_ready, 1);
        rdata = int'(reg_rdata);
        tick(1);
        chk(reg_ready == 1'b0, "R2", "ready lasts one cycle", reg_ready, 0);
        reg_valid = 1'b0; reg_we = 1'b0;
        if (we && addr < N) begin
            m_prio[addr] = wdata[3:0];
            m_en[addr]   = wdata[8];
        end
    endtask

    task automatic cfg(input int ch, input int prio, input bit en);
        int d;
        reg_access(1'b1, ch, (int'(en) << 8) | prio, d);
    endtask

    task automatic pulse(input logic [N-1:0] m);
        irq = m;
        tick(1);
        irq = '0;
        for (int i = 0; i < N; i++) if (m[i]) m_pend[i] = 1'b1;
    endtask

    task automatic do_exit();
        exit_i = 1'b1;
        tick(1);
        exit_i = 1'b0;
    endtask

    // Called right after the edge where entry should appear (or idle).
    task automatic drain();
        int b;
        forever begin
            b = model_best();
            if (b < 0) begin
                chk(!entry_o && !active_o, "R8", "idle when nothing is left", {entry_o, active_o}, 0);
                return;
            end
            chk(entry_o && !active_o, "R5", "entry phase present", {entry_o, active_o}, 2);
            chk(entry_vec_o == 8'(b + VB), "R4", "entry vector", entry_vec_o, b + VB);
            tick(E);
            chk(active_o && start_o, "R5", "active with start pulse", {active_o, start_o}, 3);
            chk(active_vec_o == 8'(b + VB), "R4", "active vector", active_vec_o, b + VB);
            m_pend[b] = 1'b0;
            tick(1 + int'($urandom % 3));
            chk(!start_o, "R5", "start is a single pulse", start_o, 0);
            do_exit();
        end
    endtask

    initial begin
        int rd;
        logic [N-1:0] m;
        void'($urandom(32'd4711));
        exit_i = 1'b0;
        for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_en[i] = 0; m_pend[i] = 0; end
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        chk(!entry_o && !active_o && !start_o && !reg_ready, "R1", "outputs idle after reset",
            {entry_o, active_o, start_o, reg_ready}, 0);
        reg_access(1'b0, 0, 0, rd);
        chk(rd == 0, "R1", "channel 0 reads zero", rd, 0);

        // R2 register map and out-of-range address
        cfg(3, 5, 1'b1);
        reg_access(1'b0, 3, 0, rd);
        chk(rd == 32'h105, "R2", "readback prio and enable", rd, 32'h105);
        reg_access(1'b1, 63, 32'h10F, rd);
        reg_access(1'b0, 63, 0, rd);
        chk(rd == 0, "R2", "out of range reads zero", rd, 0);
        cfg(3, 0, 1'b0);

        // R3 disabled pending, then enabled
        cfg(7, 9, 1'b0);
        pulse(N'(1) << 7);
        tick(2);
        chk(!entry_o && !active_o, "R3", "disabled channel not entered", {entry_o, active_o}, 0);
        reg_access(1'b0, 7, 0, rd);
        chk(rd == 32'h10009, "R3", "pending bit set while disabled", rd, 32'h10009);
        cfg(7, 9, 1'b1);
        tick(1);
        chk(entry_vec_o == 8'(7 + VB), "R3", "entered once enabled", entry_vec_o, 7 + VB);
        drain();
        reg_access(1'b0, 7, 0, rd);
        chk(rd == 32'h109, "R5", "pending cleared at start", rd, 32'h109);

        // R6 late arrival
        cfg(5, 8, 1'b1); cfg(2, 8, 1'b1); cfg(9, 3, 1'b1);
        pulse(N'(1) << 5);
        tick(1);
        chk(entry_o && entry_vec_o == 8'(5 + VB), "R6", "initial candidate", entry_vec_o, 5 + VB);
        irq = N'(1) << 2;
        tick(1);
        irq = N'(1) << 9;
        tick(1);
        irq = '0;
        m_pend[2] = 1; m_pend[9] = 1;
        chk(entry_o && entry_vec_o == 8'(5 + VB), "R6", "equal priority keeps candidate", entry_vec_o, 5 + VB);
        tick(1);
        chk(entry_o && entry_vec_o == 8'(9 + VB), "R6", "urgent late arrival replaces", entry_vec_o, 9 + VB);
        tick(1);
        chk(active_o && start_o && active_vec_o == 8'(9 + VB), "R6", "window not restarted", active_vec_o, 9 + VB);
        m_pend[9] = 0;
        do_exit();
        chk(entry_o && !active_o, "R9", "tail chain without idle", {entry_o, active_o}, 2);
        chk(entry_vec_o == 8'(2 + VB), "R4", "tie goes to lower channel", entry_vec_o, 2 + VB);
        drain();

        // R7 preemption, R8 resume, R9 tail chain
        cfg(10, 6, 1'b1); cfg(11, 6, 1'b1); cfg(12, 2, 1'b1);
        pulse(N'(1) << 10);
        tick(1);
        tick(E);
        chk(active_o && active_vec_o == 8'(10 + VB), "R7", "first handler active", active_vec_o, 10 + VB);
        m_pend[10] = 0;
        pulse(N'(1) << 11);
        tick(1);
        chk(active_o && !entry_o && active_vec_o == 8'(10 + VB), "R7", "equal priority does not preempt",
            active_vec_o, 10 + VB);
        pulse(N'(1) << 12);
        tick(1);
        chk(entry_o && !active_o && entry_vec_o == 8'(12 + VB), "R7", "strictly urgent preempts",
            entry_vec_o, 12 + VB);
        tick(E);
        chk(active_o && active_vec_o == 8'(12 + VB) && active_prio_o == 4'd2, "R7", "nested handler",
            active_vec_o, 12 + VB);
        m_pend[12] = 0;
        do_exit();
        chk(active_o && !entry_o && active_vec_o == 8'(10 + VB), "R8", "resume suspended handler",
            active_vec_o, 10 + VB);
        do_exit();
        chk(entry_o && !active_o && entry_vec_o == 8'(11 + VB), "R9", "chain after last exit",
            entry_vec_o, 11 + VB);
        drain();

        // R10 exit ignored in idle and entry
        do_exit();
        chk(!entry_o && !active_o, "R10", "exit in idle ignored", {entry_o, active_o}, 0);
        cfg(20, 1, 1'b1);
        pulse(N'(1) << 20);
        tick(1);
        chk(entry_o, "R10", "entry begun", entry_o, 1);
        do_exit();
        tick(E - 1);
        chk(active_o && start_o && active_vec_o == 8'(20 + VB), "R10", "exit during entry ignored",
            active_vec_o, 20 + VB);
        m_pend[20] = 0;
        do_exit();
        drain();

        // R4 random configurations and request sets
        for (int r = 0; r < 25; r++) begin
            for (int k = 0; k < 5; k++) begin
                int ch = int'($urandom % N);
                int p  = int'($urandom % 16);
                bit en = m_pend[ch] ? 1'b0 : (($urandom % 4) != 0);
                cfg(ch, p, en);
            end
            for (int i = 0; i < N; i++) m[i] = (($urandom % 4) == 0);
            pulse(m);
            tick(1);
            drain();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all watchdog expired: actual %0d expected %0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule